// File: doc/BRIEF.md
# Dual Capture/Compare Timer

This block holds two independent timer channels behind a small memory-mapped register port. Each channel has a control word, a load word and a live count word. A channel either runs as a compare (generate) timer that signals each time its count passes the terminal value, or as a capture timer that stores its count into the load word when an external input rises. It counts up or down. A single reload bit decides what happens at a terminal value or at a repeated capture.

Software writes a start value to the load word and pulses the load bit to copy that value into the count. It then enables the channel. The channel's own enable bit starts it alone. A shared start-all bit, reachable through either channel's control word, runs both channels together. Each rollover or capture sets a sticky event flag. The flag drives the interrupt output when the channel allows it. In compare mode a rollover can also produce a one-clock pulse on that channel's generate output. The control word also stores a pulse-width bit (bit 9) and a chaining bit (bit 11), but they have no effect on behaviour.

Each channel runs a three-state sequencer:
- STOP: not running. STOP goes to RUN when the channel is enabled.
- RUN: counting. RUN goes back to STOP when disabled. It goes to PARK when a compare-mode channel with reload clear passes its terminal value.
- PARK: frozen at the terminal value. PARK goes back to RUN when the load bit is seen while the channel is enabled, and to STOP when it is disabled.

Top module: `dual_tmr`

## Requirements
- R1: Address decoding works as follows. bus_addr[4] selects the channel. bus_addr[3:2] selects the word: 0 is control, 1 is load, 2 is count, and 3 reads as zero. When bus_re is high at a clock edge, bus_rdata shows the selected word after that edge. Writes to the count word are ignored.
- R2: The control word fields are:
  - bit 0: capture mode (0 means compare mode)
  - bit 1: count down
  - bit 2: generate output enable
  - bit 3: capture input enable
  - bit 4: reload
  - bit 5: load
  - bit 6: interrupt enable
  - bit 7: channel enable
  - bit 8: event flag
  - bit 9: stored only
  - bit 10: start-all
  - bit 11: stored only

  Bits 0-7, 9 and 11 read back as written. Writing 1 to bit 8 clears the flag and writing 0 to it leaves the flag unchanged. Bit 10 reads back the shared start-all state in both channels. Bits 9 and 11 do not change counting.
- R3: While the load bit is set, the count takes the load word on every clock, and no counting happens.
- R4: While enabled, the count changes by one per clock, upward, or downward when bit 1 is set. While disabled, the count holds. Counting begins on the first edge after the enabling write.
- R5: In compare mode with reload set, a step taken at the terminal value (all ones counting up, zero counting down) copies the load word into the count, and counting continues.
- R6: In compare mode with reload clear, a step at the terminal value leaves the count at that value and enters PARK. PARK is left through the load bit.
- R7: In capture mode with bit 3 set and reload set, every synchronized rising edge of the capture input copies the count into the load word.
- R8: In capture mode with reload clear, the first capture is kept. Later captures are dropped until software reads or writes the load word.
- R9: A capture input edge has no effect unless both bit 0 and bit 3 are set.
- R10: A rollover or an accepted capture sets the event flag. irq_o is high while any channel has both its flag and its interrupt enable set.
- R11: With bit 2 set, each rollover gives exactly one clock high on that channel's gen_out bit.
- R12: Setting the start-all bit runs both channels from the same edge. Clearing it stops any channel whose own enable bit is clear.
- R13: After reset, every word reads zero and gen_out and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a read of the load word also releases a held capture |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after bus_re |
| cap_in | input | 2 | Asynchronous capture inputs, one per channel |
| gen_out | output | 2 | Generate pulses, one per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The stepping and park properties assume that software never writes the count word expecting it to change. They also assume that the load bit is the only route out of PARK. The bench keeps to both rules.

The capture-hold property assumes that the load word changes only through a software write or an accepted capture. To meet this, the bench holds each capture input level for several clocks, so every edge passes the two-flop synchroniser cleanly. The bench also uses only one strobe per bus cycle, so a control write and a load write never coincide.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int REG_W = 32;

    // control word bit positions (software-visible)
    localparam int B_CAPMODE = 0;
    localparam int B_DOWN    = 1;
    localparam int B_GENEN   = 2;
    localparam int B_CAPEN   = 3;
    localparam int B_RELOAD  = 4;
    localparam int B_LOAD    = 5;
    localparam int B_IRQEN   = 6;
    localparam int B_RUN     = 7;
    localparam int B_FLAG    = 8;
    localparam int B_PWM     = 9;
    localparam int B_ALL     = 10;
    localparam int B_CHAIN   = 11;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_PARK = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        RG_CTRL  = 2'd0,
        RG_LOAD  = 2'd1,
        RG_COUNT = 2'd2,
        RG_NONE  = 2'd3
    } tmr_reg_e;

    typedef struct packed {
        logic chain;
        logic pwm;
        logic run_en;
        logic irq_en;
        logic ld;
        logic reload;
        logic cap_en;
        logic gen_en;
        logic down;
        logic cap_mode;
    } tmr_ctrl_t;

    function automatic tmr_ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        tmr_ctrl_t c;
        c.chain    = w[B_CHAIN];
        c.pwm      = w[B_PWM];
        c.run_en   = w[B_RUN];
        c.irq_en   = w[B_IRQEN];
        c.ld       = w[B_LOAD];
        c.reload   = w[B_RELOAD];
        c.cap_en   = w[B_CAPEN];
        c.gen_en   = w[B_GENEN];
        c.down     = w[B_DOWN];
        c.cap_mode = w[B_CAPMODE];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input tmr_ctrl_t c,
                                                      input logic flag,
                                                      input logic all);
        logic [REG_W-1:0] w;
        w            = '0;
        w[B_CHAIN]   = c.chain;
        w[B_ALL]     = all;
        w[B_PWM]     = c.pwm;
        w[B_FLAG]    = flag;
        w[B_RUN]     = c.run_en;
        w[B_IRQEN]   = c.irq_en;
        w[B_LOAD]    = c.ld;
        w[B_RELOAD]  = c.reload;
        w[B_CAPEN]   = c.cap_en;
        w[B_GENEN]   = c.gen_en;
        w[B_DOWN]    = c.down;
        w[B_CAPMODE] = c.cap_mode;
        return w;
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[SH_W-2:0], async_i};
    end

    // shift_q[STAGES-1] is the synchronised level, shift_q[STAGES] its previous value
    assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];

    AST_RISE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R7

endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             load_wr_i,
    input  logic             load_rd_i,
    input  logic             all_i,
    input  logic             cap_rise_i,
    output tmr_ctrl_t        ctrl_o,
    output logic             flag_o,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             gen_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       st_q, st_d;
    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] load_q;
    logic             full_q;
    logic             flag_q;
    logic             gen_q;

    logic run, at_term, step, roll, cap_hit, cap_take;

    // ---------------- datapath conditions ----------------
    always_comb begin
        run      = ctrl_q.run_en | all_i;
        at_term  = ctrl_q.down ? (cnt_q == '0) : (cnt_q == '1);
        step     = run && (st_q != ST_PARK) && !ctrl_q.ld;
        roll     = step && at_term;
        cap_hit  = cap_rise_i && ctrl_q.cap_mode && ctrl_q.cap_en;
        cap_take = cap_hit && !load_wr_i && (ctrl_q.reload || !full_q);
    end

    // ---------------- sequencer next state ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_STOP: if (run) st_d = ST_RUN;
            ST_RUN: begin
                if (!run)
                    st_d = ST_STOP;
                else if (roll && !ctrl_q.cap_mode && !ctrl_q.reload)
                    st_d = ST_PARK;
            end
            ST_PARK: begin
                if (!run)           st_d = ST_STOP;
                else if (ctrl_q.ld) st_d = ST_RUN;
            end
            default: st_d = ST_STOP;
        endcase
    end

    // ---------------- count next value ----------------
    always_comb begin
        cnt_d = cnt_q;
        if (ctrl_q.ld)
            cnt_d = load_q;
        else if (roll && !ctrl_q.cap_mode)
            cnt_d = ctrl_q.reload ? load_q : cnt_q;
        else if (step)
            cnt_d = ctrl_q.down ? (cnt_q - ONE) : (cnt_q + ONE);
    end

    // ---------------- state and register process ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_STOP;
            ctrl_q <= '0;
            cnt_q  <= '0;
            load_q <= '0;
            full_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (ctrl_wr_i)
                ctrl_q <= ctrl_from_word(wdata_i);
            if (load_wr_i)
                load_q <= wdata_i[CNT_W-1:0];
            else if (cap_take)
                load_q <= cnt_q;
            if (cap_take)
                full_q <= 1'b1;
            else if (load_wr_i || load_rd_i)
                full_q <= 1'b0;
            if (roll || cap_take)
                flag_q <= 1'b1;
            else if (ctrl_wr_i && wdata_i[B_FLAG])
                flag_q <= 1'b0;
        end
    end

    // ---------------- output process ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= 1'b0;
        else        gen_q <= roll && ctrl_q.gen_en;
    end

    assign ctrl_o = ctrl_q;
    assign flag_o = flag_q;
    assign load_o = load_q;
    assign cnt_o  = cnt_q;
    assign gen_o  = gen_q;

    // ---------------- assertions ----------------
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.ld |=> (cnt_q == $past(load_q))); // R3

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_term && !ctrl_q.down) |=> (cnt_q == $past(cnt_q) + ONE)); // R4

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_term && ctrl_q.down) |=> (cnt_q == $past(cnt_q) - ONE)); // R4

    AST_PARK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PARK && !ctrl_q.ld) |=> $stable(cnt_q)); // R6

    AST_CAPTURE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !ctrl_q.reload && !load_wr_i) |=> $stable(load_q)); // R8

    AST_GEN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q |-> flag_q); // R11

endmodule

// File: rtl/tmr_bus_decode.sv
`timescale 1ns/1ps
module tmr_bus_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int SEL_W  = 1,
    parameter int ADDR_W = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we_i,
    input  logic                         re_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [NUM_CH-1:0][REG_W-1:0] ctrl_words_i,
    input  logic [NUM_CH-1:0][REG_W-1:0] load_words_i,
    input  logic [NUM_CH-1:0][REG_W-1:0] cnt_words_i,
    output logic [NUM_CH-1:0]            ctrl_wr_o,
    output logic [NUM_CH-1:0]            load_wr_o,
    output logic [NUM_CH-1:0]            load_rd_o,
    output logic [REG_W-1:0]             rdata_o
);
    logic [SEL_W-1:0] ch_sel;
    tmr_reg_e         reg_sel;
    logic [REG_W-1:0] rd_mux;
    logic             unused_addr_bits;

    assign ch_sel           = addr_i[ADDR_W-1:4];
    assign reg_sel          = tmr_reg_e'(addr_i[3:2]);
    assign unused_addr_bits = ^addr_i[1:0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_strobe
        logic hit;
        assign hit          = (ch_sel == SEL_W'(i));
        assign ctrl_wr_o[i] = we_i && hit && (reg_sel == RG_CTRL);
        assign load_wr_o[i] = we_i && hit && (reg_sel == RG_LOAD);
        assign load_rd_o[i] = re_i && hit && (reg_sel == RG_LOAD);
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_sel == SEL_W'(i)) begin
                unique case (reg_sel)
                    RG_CTRL:  rd_mux = ctrl_words_i[i];
                    RG_LOAD:  rd_mux = load_words_i[i];
                    RG_COUNT: rd_mux = cnt_words_i[i];
                    RG_NONE:  rd_mux = '0;
                    default:  rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata_o <= '0;
        else if (re_i) rdata_o <= rd_mux;
        else           rdata_o <= '0;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_wr_o, load_wr_o})); // R1

endmodule

// File: rtl/dual_tmr.sv
`timescale 1ns/1ps
module dual_tmr
    import tmr_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W     = SEL_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0] cap_in,
    output logic [NUM_CH-1:0] gen_out,
    output logic              irq_o
);
    logic [NUM_CH-1:0]            ctrl_wr, load_wr, load_rd;
    logic [NUM_CH-1:0][REG_W-1:0] ctrl_words, load_words, cnt_words;
    logic [NUM_CH-1:0]            flags, irq_req, cap_rise;
    logic                         all_q;
    logic                         unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata[REG_W-1:B_CHAIN+1];

    // shared start-all state, written through any channel's control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        all_q <= 1'b0;
        else if (|ctrl_wr) all_q <= bus_wdata[B_ALL];
    end

    tmr_bus_decode #(
        .NUM_CH (NUM_CH),
        .SEL_W  (SEL_W),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (bus_we),
        .re_i         (bus_re),
        .addr_i       (bus_addr),
        .ctrl_words_i (ctrl_words),
        .load_words_i (load_words),
        .cnt_words_i  (cnt_words),
        .ctrl_wr_o    (ctrl_wr),
        .load_wr_o    (load_wr),
        .load_rd_o    (load_rd),
        .rdata_o      (bus_rdata)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr_ctrl_t        ctrl;
        logic [CNT_W-1:0] load_v, cnt_v;

        tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (cap_in[i]),
            .rise_o  (cap_rise[i])
        );

        tmr_channel #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_wr_i  (ctrl_wr[i]),
            .wdata_i    (bus_wdata),
            .load_wr_i  (load_wr[i]),
            .load_rd_i  (load_rd[i]),
            .all_i      (all_q),
            .cap_rise_i (cap_rise[i]),
            .ctrl_o     (ctrl),
            .flag_o     (flags[i]),
            .load_o     (load_v),
            .cnt_o      (cnt_v),
            .gen_o      (gen_out[i])
        );

        assign ctrl_words[i] = ctrl_to_word(ctrl, flags[i], all_q);
        assign load_words[i] = REG_W'(load_v);
        assign cnt_words[i]  = REG_W'(cnt_v);
        assign irq_req[i]    = flags[i] & ctrl.irq_en;
    end

    assign irq_o = |irq_req;

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (|flags)); // R10

endmodule

// File: tb/dual_tmr_bench.sv
`timescale 1ns/1ps
module dual_tmr_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cap_in = '0;
    logic [1:0]  gen_out;
    logic        irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    int gen_seen [2];

    localparam logic [4:0] C0 = 5'h00, L0 = 5'h04, N0 = 5'h08;
    localparam logic [4:0] C1 = 5'h10, L1 = 5'h14, N1 = 5'h18;

    always #2.5 clk = ~clk;

    dual_tmr u_dual_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .gen_out   (gen_out),
        .irq_o     (irq_o)
    );

    initial begin
        gen_seen[0] = 0;
        gen_seen[1] = 0;
    end

    always @(negedge clk) begin
        if (gen_out[0]) gen_seen[0] = gen_seen[0] + 1;
        if (gen_out[1]) gen_seen[1] = gen_seen[1] + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_cap(input int ch);
        cap_in[ch] = 1'b1;
        idle(4);
        cap_in[ch] = 1'b0;
        idle(4);
    endtask

    // clear flag, load a start value into the count, leave the channel stopped
    task automatic prime(input logic [4:0] cw, input logic [4:0] lw, input logic [31:0] v);
        wr(lw, v);
        wr(cw, 32'h120);
        wr(cw, 32'h000);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R13 gen_out", {30'd0, gen_out}, 32'd0);
        check("R13 irq", {31'd0, irq_o}, 32'd0);
        rd(C0, d); check("R13 ctrl0", d, 32'h0);
        rd(L1, d); check("R13 load1", d, 32'h0);
        rd(N1, d); check("R13 count1", d, 32'h0);
        rd(5'h0C, d); check("R1 unused word", d, 32'h0);
    endtask

    task automatic t_ctrl_bits;
        logic [31:0] d;
        wr(C0, 32'h0000_0A40);
        rd(C0, d); check("R2 readback", d, 32'h0000_0A40);
        wr(C1, 32'h0000_0400);
        rd(C0, d); check("R2 shared start-all", d, 32'h0000_0E40);
        wr(C1, 32'h0);
        wr(C0, 32'h0);
        rd(C1, d); check("R2 start-all cleared", d, 32'h0);
    endtask

    task automatic t_load_priority;
        logic [31:0] d;
        wr(L0, 32'h55);
        wr(C0, 32'hA0);
        idle(5);
        rd(N0, d); check("R3 load holds count", d, 32'h55);
        wr(C0, 32'h0);
    endtask

    task automatic t_count_dirs;
        logic [31:0] d;
        prime(C0, L0, 32'd100);
        wr(C0, 32'hA80);
        idle(9);
        wr(C0, 32'hA00);
        rd(N0, d); check("R4 up count, R2 stored bits inert", d, 32'd110);
        idle(5);
        rd(N0, d); check("R4 stopped holds", d, 32'd110);
        prime(C0, L0, 32'd100);
        wr(C0, 32'h82);
        idle(9);
        wr(C0, 32'h02);
        rd(N0, d); check("R4 down count", d, 32'd90);
        wr(C0, 32'h0);
    endtask

    task automatic t_reload;
        logic [31:0] d;
        int g0;
        prime(C0, L0, 32'hFFFF_FFFC);
        g0 = gen_seen[0];
        wr(C0, 32'hD4);
        idle(9);
        wr(C0, 32'h54);
        rd(N0, d); check("R5 reload wrap", d, 32'hFFFF_FFFE);
        idle(2);
        check("R11 gen pulses", gen_seen[0] - g0, 32'd2);
        check("R10 irq set", {31'd0, irq_o}, 32'd1);
        wr(C0, 32'h54);
        rd(C0, d); check("R2 write 0 keeps flag", d, 32'h154);
        wr(C0, 32'h154);
        rd(C0, d); check("R2 write 1 clears flag", d, 32'h54);
        check("R10 irq cleared", {31'd0, irq_o}, 32'd0);
        wr(C0, 32'h0);
    endtask

    task automatic t_park;
        logic [31:0] d;
        int g0;
        prime(C0, L0, 32'd3);
        g0 = gen_seen[0];
        wr(C0, 32'h86);
        idle(20);
        rd(N0, d); check("R6 parked at zero", d, 32'd0);
        check("R11 single pulse", gen_seen[0] - g0, 32'd1);
        rd(C0, d); check("R10 flag in park", d, 32'h186);
        check("R10 irq masked", {31'd0, irq_o}, 32'd0);
        wr(L0, 32'd5);
        wr(C0, 32'hA6);
        wr(C0, 32'h86);
        idle(1);
        wr(C0, 32'h06);
        rd(N0, d); check("R6 restart by load", d, 32'd3);
        wr(C0, 32'h100);
    endtask

    task automatic t_capture;
        logic [31:0] d;
        prime(C0, L0, 32'h1234);
        wr(L0, 32'h0);
        wr(C0, 32'h09);
        pulse_cap(0);
        rd(C0, d); check("R10 capture flag", d, 32'h109);
        wr(C0, 32'h89);
        idle(4);
        wr(C0, 32'h09);
        pulse_cap(0);
        rd(L0, d); check("R8 first capture kept", d, 32'h1234);
        pulse_cap(0);
        rd(L0, d); check("R8 capture after read", d, 32'h1239);
        wr(C0, 32'h19);
        pulse_cap(0);
        wr(C0, 32'h99);
        idle(4);
        wr(C0, 32'h19);
        pulse_cap(0);
        rd(L0, d); check("R7 capture overwrites", d, 32'h123E);
        wr(C0, 32'h100);
    endtask

    task automatic t_cap_ignored;
        logic [31:0] d;
        wr(C0, 32'h101);
        wr(L0, 32'h77);
        pulse_cap(0);
        rd(L0, d); check("R9 no enable bit", d, 32'h77);
        wr(C0, 32'h08);
        pulse_cap(0);
        rd(L0, d); check("R9 compare mode", d, 32'h77);
        rd(C0, d); check("R9 no flag", d, 32'h08);
        wr(C0, 32'h0);
    endtask

    task automatic t_start_all;
        logic [31:0] d;
        prime(C0, L0, 32'd10);
        prime(C1, L1, 32'd20);
        wr(C0, 32'h400);
        rd(C1, d); check("R12 seen in other channel", d, 32'h400);
        idle(3);
        wr(C0, 32'h0);
        rd(N0, d); check("R12 channel 0 ran", d, 32'd15);
        rd(N1, d); check("R12 channel 1 ran", d, 32'd25);
        wr(N1, 32'hDEAD);
        rd(N1, d); check("R1 count write ignored", d, 32'd25);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_ctrl_bits;
        t_load_priority;
        t_count_dirs;
        t_reload;
        t_park;
        t_capture;
        t_cap_ignored;
        t_start_all;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule